// File: doc/BRIEF.md
# Accumulator Fetch-Execute Sequencer

This block is the control path and register set of a tiny one-accumulator processor. A timing-state counter walks each instruction through a fixed schedule. The first two states fetch the instruction word and advance the program counter. The next state decodes the word and latches its address field. A fourth state either reads a pointer from memory, when the instruction is indirect, or carries out a register-class operation. Two further states fetch the operand and add it into the accumulator, which also updates a carry flag.

The block drives a word address to a memory outside it. It expects that memory to return read data one clock after the address is presented. The address output is chosen combinationally for each state so that the returned word arrives in the state that needs it.

The start address and the reset value of the accumulator are parameters. A halt code in the register class freezes the machine so that its final state can be read at the ports.

Top module: `acs_core`

## Requirements
- R1: While `rst` is high at a clock edge, the next state is: PC = `START_PC`, AC = `AC_INIT`, E = 0, `tstate_o` = 0 and `halted_o` = 0.
- R2: In state 0 `mem_addr` equals the PC. In state 1 the returned word is taken as the instruction and the PC increases by one.
- R3: An instruction word uses bit 15 as the indirect flag, bits 14:12 as the opcode and bits 11:0 as the address field. Opcode 001 is ADD and opcode 111 is the register class.
- R4: A direct ADD reads its operand from the address field. It takes states 0 to 5 (six clocks) and then returns to state 0. State 6 is never entered.
- R5: An indirect ADD (bit 15 = 1) reads a pointer word at the address field in state 3. It then reads its operand at the pointer's low 12 bits.
- R6: ADD sets AC to the low 16 bits of AC + operand, and sets E to the carry out of bit 15.
- R7: A register-class word (opcode 111, bit 15 = 0) acts in state 3 and then returns to state 0. Field bit 11 clears AC and field bit 10 clears E.
- R8: The register-class field value 0x001 sets `halted_o`. After that, PC, AC, E and `tstate_o` (held at 0) stay unchanged until reset.
- R9: Any other opcode changes only the PC and returns to state 0 after state 3.
- R10: In state 2 `mem_addr` shows the address field. In state 3 it shows the operand address: the pointer word's low 12 bits when indirect, the address field otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 12 | Word address to memory |
| mem_rdata | input | 16 | Memory read data, one clock after the address |
| pc_o | output | 12 | Program counter |
| ac_o | output | 16 | Accumulator |
| e_o | output | 1 | Carry flag |
| halted_o | output | 1 | Machine stopped by halt |
| tstate_o | output | 3 | Current timing state |

## Verification
An ADD's accumulator, carry and PC results are due six clock edges after its state-0 edge. A register-class result, including halt, is due four edges after that edge. The bench counts exactly those edges from the release of reset and samples on falling edges, so it always looks at a completed instruction with the counter back in state 0. Within each ADD the address output is also sampled after the second and third edges, which checks the state-2 address field and the state-3 operand address at the cycle they must be stable. Halt is checked by watching the outputs stay frozen for several further cycles.

// File: rtl/acs_pkg.sv
package acs_pkg;
    localparam int WORD_W = 16;
    localparam int ADDR_W = 12;

    typedef enum logic [2:0] {
        TS0, TS1, TS2, TS3, TS4, TS5, TS6
    } tstate_e;

    typedef struct packed {
        logic              ind;
        logic [2:0]        op;
        logic [ADDR_W-1:0] field;
    } instr_t;

    localparam logic [2:0]        OP_ADD   = 3'b001;
    localparam logic [2:0]        OP_REG   = 3'b111;
    localparam logic [ADDR_W-1:0] RF_HALT  = 12'h001;
    localparam int                RF_CLA_B = 11;
    localparam int                RF_CLE_B = 10;

    typedef struct packed {
        logic is_add;
        logic is_reg;
        logic is_mem;
    } dec_t;

    function automatic dec_t decode(instr_t w);
        dec_t d;
        d.is_reg = (w.op == OP_REG) && !w.ind;
        d.is_mem = (w.op != OP_REG);
        d.is_add = (w.op == OP_ADD);
        return d;
    endfunction
endpackage

// File: rtl/acs_seq_ctr.sv
module acs_seq_ctr
    import acs_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    hold,
    input  logic    clr,
    output tstate_e ts
);
    always_ff @(posedge clk) begin
        if (rst)       ts <= TS0;
        else if (hold) ts <= ts;
        else if (clr)  ts <= TS0;
        else           ts <= tstate_e'(ts + 3'd1);
    end
endmodule

// File: rtl/acs_adder.sv
module acs_adder #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W:0]   sum
);
    always_comb sum = {1'b0, a} + {1'b0, b};
endmodule

// File: rtl/acs_addr_sel.sv
module acs_addr_sel
    import acs_pkg::*;
(
    input  tstate_e           ts,
    input  logic              ind_q,
    input  logic              is_mem,
    input  logic [ADDR_W-1:0] pc,
    input  logic [ADDR_W-1:0] ar,
    input  logic [ADDR_W-1:0] field,
    input  logic [ADDR_W-1:0] ptr,
    output logic [ADDR_W-1:0] addr
);
    always_comb begin
        case (ts)
            TS0:     addr = pc;
            TS2:     addr = field;
            TS3:     addr = (is_mem && ind_q) ? ptr : ar;
            default: addr = ar;
        endcase
    end
endmodule

// File: rtl/acs_core.sv
module acs_core
    import acs_pkg::*;
#(
    parameter logic [11:0] START_PC = 12'h000,
    parameter logic [15:0] AC_INIT  = 16'h0000
) (
    input  logic        clk,
    input  logic        rst,
    output logic [11:0] mem_addr,
    input  logic [15:0] mem_rdata,
    output logic [11:0] pc_o,
    output logic [15:0] ac_o,
    output logic        e_o,
    output logic        halted_o,
    output logic [2:0]  tstate_o
);
    logic [ADDR_W-1:0] pc, ar;
    logic [WORD_W-1:0] ac, dr;
    instr_t            ir;
    logic              e, ind_q, halted;
    dec_t              dec;
    tstate_e           ts;
    logic [WORD_W:0]   sum;
    logic              seq_clr;

    always_comb dec = decode(ir);
    always_comb seq_clr = ((ts == TS3) && !dec.is_add) || (ts == TS5);

    acs_seq_ctr u_seq (
        .clk  (clk),
        .rst  (rst),
        .hold (halted),
        .clr  (seq_clr),
        .ts   (ts)
    );

    acs_adder #(.W(WORD_W)) u_add (
        .a   (ac),
        .b   (dr),
        .sum (sum)
    );

    acs_addr_sel u_asel (
        .ts     (ts),
        .ind_q  (ind_q),
        .is_mem (dec.is_mem),
        .pc     (pc),
        .ar     (ar),
        .field  (ir.field),
        .ptr    (mem_rdata[ADDR_W-1:0]),
        .addr   (mem_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc     <= START_PC;
            ac     <= AC_INIT;
            e      <= 1'b0;
            halted <= 1'b0;
            ar     <= '0;
            ir     <= '0;
            dr     <= '0;
            ind_q  <= 1'b0;
        end else if (!halted) begin
            case (ts)
                TS0: ar <= pc;
                TS1: begin
                    ir <= instr_t'(mem_rdata);
                    pc <= pc + 1'b1;
                end
                TS2: begin
                    ar    <= ir.field;
                    ind_q <= ir.ind;
                end
                TS3: begin
                    if (dec.is_mem && ind_q) ar <= mem_rdata[ADDR_W-1:0];
                    if (dec.is_reg) begin
                        if (ir.field[RF_CLA_B]) ac <= '0;
                        if (ir.field[RF_CLE_B]) e  <= 1'b0;
                        if (ir.field == RF_HALT) halted <= 1'b1;
                    end
                end
                TS4: if (dec.is_add) dr <= mem_rdata;
                TS5: if (dec.is_add) {e, ac} <= sum;
                default: ;
            endcase
        end
    end

    assign pc_o     = pc;
    assign ac_o     = ac;
    assign e_o      = e;
    assign halted_o = halted;
    assign tstate_o = ts;
endmodule

// File: rtl/acs_core_chk.sv
module acs_core_chk (
    input logic        clk,
    input logic        rst,
    input logic [11:0] mem_addr,
    input logic [11:0] pc_o,
    input logic [15:0] ac_o,
    input logic        e_o,
    input logic        halted_o,
    input logic [2:0]  tstate_o
);
    // R2: state 0 presents the PC to memory
    a_r2_fetch_addr: assert property (@(posedge clk) disable iff (rst)
        (tstate_o == 3'd0 && !halted_o) |-> mem_addr == pc_o);

    // R2: PC steps by one across state 1
    a_r2_pc_step: assert property (@(posedge clk) disable iff (rst)
        (tstate_o == 3'd1 && !halted_o) |=> pc_o == $past(pc_o) + 12'd1);

    // R4: state 6 is never reached, state 5 wraps to 0
    a_r4_no_t6: assert property (@(posedge clk) disable iff (rst)
        tstate_o != 3'd6);
    a_r4_wrap: assert property (@(posedge clk) disable iff (rst)
        (tstate_o == 3'd5) |=> tstate_o == 3'd0);

    // R6: carry only moves on states 3 and 5
    a_r6_e_window: assert property (@(posedge clk) disable iff (rst)
        (tstate_o != 3'd3 && tstate_o != 3'd5) |=> $stable(e_o));

    // R8: halt freezes visible state
    a_r8_halt_freeze: assert property (@(posedge clk) disable iff (rst)
        halted_o |=> (halted_o && $stable(pc_o) && $stable(ac_o)
                      && $stable(e_o) && tstate_o == 3'd0));
endmodule

bind acs_core acs_core_chk u_chk (.*);

// File: tb/acs_core_tb.sv
module acs_core_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] mem_addr;
    logic [15:0] mem_rdata;
    logic [11:0] pc_o;
    logic [15:0] ac_o;
    logic        e_o, halted_o;
    logic [2:0]  tstate_o;

    logic [15:0] mem [4096];
    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    always_ff @(posedge clk) mem_rdata <= mem[mem_addr];

    acs_core #(.START_PC(12'h5AF), .AC_INIT(16'h7EC3)) u_dut (
        .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .pc_o(pc_o), .ac_o(ac_o), .e_o(e_o), .halted_o(halted_o),
        .tstate_o(tstate_o)
    );

    // {instruction, pointer word, operand}
    localparam logic [47:0] VEC [5] = '{
        {16'h932E, 16'h09AC, 16'h8B9F},
        {16'h1100, 16'h0000, 16'h0001},
        {16'h1101, 16'h0000, 16'hF5A0},
        {16'h9200, 16'h0300, 16'h1234},
        {16'h1102, 16'h0000, 16'hFFFF}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        logic [15:0] ac_m;
        logic        e_m;
        logic [11:0] pc_m;
        logic [16:0] s;
        for (int i = 0; i < 4096; i++) mem[i] = 16'h0;
        for (int k = 0; k < 5; k++) begin
            logic [15:0] w, p, d;
            {w, p, d} = VEC[k];
            mem[12'h5AF + k] = w;
            if (w[15]) begin
                mem[w[11:0]] = p;
                mem[p[11:0]] = d;
            end else mem[w[11:0]] = d;
        end
        mem[12'h5B4] = 16'h7400;  // clear E
        mem[12'h5B5] = 16'h2105;  // other opcode
        mem[12'h5B6] = 16'h7800;  // clear AC
        mem[12'h5B7] = 16'h7001;  // halt

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 pc", pc_o, 12'h5AF);
        chk("R1 ac", ac_o, 16'h7EC3);
        chk("R1 e", e_o, 1'b0);
        chk("R1 tstate", tstate_o, 3'd0);
        chk("R1 halted", halted_o, 1'b0);
        chk("R2 fetch addr", mem_addr, 12'h5AF);
        rst = 1'b0;

        ac_m = 16'h7EC3; e_m = 1'b0; pc_m = 12'h5AF;
        for (int k = 0; k < 5; k++) begin
            logic [15:0] w, p, d;
            {w, p, d} = VEC[k];
            run(2);
            chk("R10 state2 addr", mem_addr, w[11:0]);
            chk("R2 pc step", pc_o, pc_m + 12'd1);
            run(1);
            chk(w[15] ? "R5 indirect addr" : "R10 direct addr",
                mem_addr, w[15] ? p[11:0] : w[11:0]);
            run(3);
            s = {1'b0, ac_m} + {1'b0, d};
            ac_m = s[15:0]; e_m = s[16]; pc_m = pc_m + 12'd1;
            chk("R6 ac", ac_o, ac_m);
            chk("R6 e", e_o, e_m);
            chk("R4 back to T0", tstate_o, 3'd0);
            chk("R3 pc", pc_o, pc_m);
        end

        run(4); pc_m = pc_m + 12'd1;  // clear E
        chk("R7 cle e", e_o, 1'b0);
        chk("R7 cle ac", ac_o, ac_m);
        chk("R7 T0", tstate_o, 3'd0);
        run(4); pc_m = pc_m + 12'd1;  // other opcode
        chk("R9 ac", ac_o, ac_m);
        chk("R9 e", e_o, 1'b0);
        chk("R9 pc", pc_o, pc_m);
        chk("R9 T0", tstate_o, 3'd0);
        run(4); pc_m = pc_m + 12'd1;  // clear AC
        chk("R7 cla ac", ac_o, 16'h0);
        run(4); pc_m = pc_m + 12'd1;  // halt
        chk("R8 halted", halted_o, 1'b1);
        chk("R8 pc", pc_o, pc_m);
        run(8);
        chk("R8 frozen pc", pc_o, pc_m);
        chk("R8 frozen ac", ac_o, 16'h0);
        chk("R8 frozen tstate", tstate_o, 3'd0);
        chk("R8 still halted", halted_o, 1'b1);

        rst = 1'b1;
        run(1);
        chk("R1 rerun pc", pc_o, 12'h5AF);
        chk("R1 rerun ac", ac_o, 16'h7EC3);
        chk("R1 rerun halted", halted_o, 1'b0);
        rst = 1'b0;
        run(6);
        chk("R6 example ac", ac_o, 16'h0A62);
        chk("R6 example e", e_o, 1'b1);
        chk("R2 example pc", pc_o, 12'h5B0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule